// File: doc/BRIEF.md
# Program-Memory Table Read Unit

This unit performs the table-lookup operation of a small microcontroller core. Software first loads an 8-bit table pointer through the data-side register port. Then an instruction asks for a lookup. The unit forms a 10-bit program-memory address and reads one 14-bit word from a synchronous program memory. It splits that word into two results. The low byte goes to the data register named by the instruction. The upper six bits are kept in a read-only high-result register, which software reads afterwards.

Each lookup chooses where the upper two address bits come from. They are either the page bits of the current program counter, so the table sits in the page the code runs from, or the fixed last page of program memory. A lookup takes two cycles. The first cycle reads the memory and the second cycle delivers the low byte. While a lookup is in progress the unit reports busy and does not accept another start.

Top module: `tblrd_unit`

## Requirements
- R1: After reset, `busy`, `rom_rd` and `dst_we` are 0. Reads of register address 07H and 08H both return 00H.
- R2: A write to data address 07H loads the table pointer. A read of 07H returns the last value written.
- R3: A start with `page_last`=0 reads the memory at address {`pc_page`, pointer}. `pc_page` is taken from the start cycle, and the pointer is the value held before that cycle's edge. The address occupies bits 9..8 and 7..0 respectively.
- R4: A start with `page_last`=1 reads the memory at address {2'b11, pointer}, whatever the value of `pc_page`.
- R5: In the second cycle of a lookup, `dst_we` is 1 for exactly one cycle. `dst_data` carries bits 7..0 of the fetched word, and `dst_addr` carries the `dest_sel` value given with the start.
- R6: After a lookup completes, a read of 08H returns bits 13..8 of the fetched word in bits 5..0, with bits 7..6 reading 0.
- R7: Writes to 08H are ignored. The high-result register and the pointer keep their values.
- R8: A start accepted at an edge makes `busy` 1 for the next two cycles. `rom_rd` is 1 in the first of those cycles and `dst_we` in the second. `busy` is 0 after that.
- R9: A start while `busy` is 1 is ignored. It causes no memory read and no destination write.
- R10: Reads of any data address other than 07H and 08H return 00H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Data-side register write strobe |
| cfg_wr_addr | input | 6 | Data-side write address |
| cfg_wr_data | input | 8 | Data-side write value |
| cfg_rd_addr | input | 6 | Data-side read address |
| cfg_rd_data | output | 8 | Data-side read value (combinational) |
| start | input | 1 | Lookup request |
| page_last | input | 1 | 1 = last page, 0 = current program-counter page |
| dest_sel | input | 6 | Destination data address named by the instruction |
| pc_page | input | 2 | Program counter bits 9..8 |
| rom_rd | output | 1 | Program-memory read enable |
| rom_addr | output | 10 | Program-memory address |
| rom_data | input | 14 | Program-memory word, valid the cycle after `rom_rd` |
| dst_we | output | 1 | Destination write strobe |
| dst_addr | output | 6 | Destination data address |
| dst_data | output | 8 | Low byte of the fetched word |
| busy | output | 1 | Lookup in progress |

## Verification
Take the edge where a start is accepted as edge 0. `rom_rd` and `rom_addr` are due in the cycle after edge 0. The `dst_we` strobe and its data are due in the cycle after edge 1. The high-result register can be read after edge 2, when `busy` has already fallen. The bench drives every input and samples every output on the falling clock edge. It checks each result in exactly the cycle named above, and a result that arrives one cycle early or late therefore fails. For the ignored-start case the bench holds `start` high across both busy cycles. It then checks that `busy` has fallen and that the destination still carries the first request.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_DELIVER = 2'd2
    } tr_state_e;
endpackage

// File: rtl/tblrd_addr_gen.sv
module tblrd_addr_gen #(
    parameter int ADDR_W = 10,
    parameter int PTR_W  = 8,
    localparam int PAGE_W = ADDR_W - PTR_W
) (
    input  logic [PTR_W-1:0]  ptr,
    input  logic [PAGE_W-1:0] pc_page,
    input  logic              page_last,
    output logic [ADDR_W-1:0] addr
);
    logic [PAGE_W-1:0] page_bits;

    always_comb begin
        page_bits = page_last ? {PAGE_W{1'b1}} : pc_page;
        addr      = {page_bits, ptr};
    end
endmodule

// File: rtl/tblrd_seq.sv
module tblrd_seq
    import tblrd_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DA_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DA_W-1:0]   dest_in,
    output logic              rom_rd,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              deliver,
    output logic [DA_W-1:0]   dest_out,
    output logic              busy
);
    typedef struct packed {
        tr_state_e         state;
        logic [ADDR_W-1:0] addr;
        logic [DA_W-1:0]   dest;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            ST_IDLE: begin
                if (start) begin
                    seq_d.state = ST_FETCH;
                    seq_d.addr  = addr_in;
                    seq_d.dest  = dest_in;
                end
            end
            ST_FETCH: seq_d.state = ST_DELIVER;
            default:  seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, addr: '0, dest: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rom_rd   = (seq_q.state == ST_FETCH);
    assign deliver  = (seq_q.state == ST_DELIVER);
    assign busy     = (seq_q.state != ST_IDLE);
    assign rom_addr = seq_q.addr;
    assign dest_out = seq_q.dest;
endmodule

// File: rtl/tblrd_regs.sv
module tblrd_regs #(
    parameter int             DATA_W    = 8,
    parameter int             DA_W      = 6,
    parameter int             HIGH_W    = 6,
    parameter logic [DA_W-1:0] PTR_ADDR  = 6'h07,
    parameter logic [DA_W-1:0] HIGH_ADDR = 6'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DA_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DA_W-1:0]   rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              hi_load,
    input  logic [HIGH_W-1:0] hi_data,
    output logic [DATA_W-1:0] ptr,
    output logic [HIGH_W-1:0] high
);
    typedef struct packed {
        logic [DATA_W-1:0] ptr;
        logic [HIGH_W-1:0] high;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [DATA_W-1:0] high_view;

    generate
        if (HIGH_W < DATA_W) begin : g_pad
            assign high_view = {{(DATA_W-HIGH_W){1'b0}}, regs_q.high};
        end else begin : g_full
            assign high_view = regs_q.high[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        regs_d = regs_q;
        if (wr_en && (wr_addr == PTR_ADDR)) begin
            regs_d.ptr = wr_data;
        end
        if (hi_load) begin
            regs_d.high = hi_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        if (rd_addr == PTR_ADDR) begin
            rd_data = regs_q.ptr;
        end else if (rd_addr == HIGH_ADDR) begin
            rd_data = high_view;
        end else begin
            rd_data = '0;
        end
    end

    assign ptr  = regs_q.ptr;
    assign high = regs_q.high;
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit #(
    parameter int              ADDR_W    = 10,
    parameter int              WORD_W    = 14,
    parameter int              DATA_W    = 8,
    parameter int              DA_W      = 6,
    parameter logic [DA_W-1:0] PTR_ADDR  = 6'h07,
    parameter logic [DA_W-1:0] HIGH_ADDR = 6'h08,
    localparam int             PAGE_W    = ADDR_W - DATA_W,
    localparam int             HIGH_W    = WORD_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [DA_W-1:0]   cfg_wr_addr,
    input  logic [DATA_W-1:0] cfg_wr_data,
    input  logic [DA_W-1:0]   cfg_rd_addr,
    output logic [DATA_W-1:0] cfg_rd_data,
    input  logic              start,
    input  logic              page_last,
    input  logic [DA_W-1:0]   dest_sel,
    input  logic [PAGE_W-1:0] pc_page,
    output logic              rom_rd,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [WORD_W-1:0] rom_data,
    output logic              dst_we,
    output logic [DA_W-1:0]   dst_addr,
    output logic [DATA_W-1:0] dst_data,
    output logic              busy
);
    logic [DATA_W-1:0] tbl_ptr;
    logic [HIGH_W-1:0] high_val;
    logic [ADDR_W-1:0] look_addr;
    logic              deliver;

    tblrd_addr_gen #(.ADDR_W(ADDR_W), .PTR_W(DATA_W)) u_addr (
        .ptr       (tbl_ptr),
        .pc_page   (pc_page),
        .page_last (page_last),
        .addr      (look_addr)
    );

    tblrd_seq #(.ADDR_W(ADDR_W), .DA_W(DA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .addr_in  (look_addr),
        .dest_in  (dest_sel),
        .rom_rd   (rom_rd),
        .rom_addr (rom_addr),
        .deliver  (deliver),
        .dest_out (dst_addr),
        .busy     (busy)
    );

    tblrd_regs #(
        .DATA_W(DATA_W), .DA_W(DA_W), .HIGH_W(HIGH_W),
        .PTR_ADDR(PTR_ADDR), .HIGH_ADDR(HIGH_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_wr_addr),
        .wr_data (cfg_wr_data),
        .rd_addr (cfg_rd_addr),
        .rd_data (cfg_rd_data),
        .hi_load (deliver),
        .hi_data (rom_data[WORD_W-1:DATA_W]),
        .ptr     (tbl_ptr),
        .high    (high_val)
    );

    assign dst_we   = deliver;
    assign dst_data = rom_data[DATA_W-1:0];
endmodule

// File: rtl/tblrd_unit_chk.sv
module tblrd_unit_chk #(
    parameter int              ADDR_W    = 10,
    parameter int              WORD_W    = 14,
    parameter int              DATA_W    = 8,
    parameter int              DA_W      = 6,
    parameter logic [DA_W-1:0] HIGH_ADDR = 6'h08,
    localparam int             PAGE_W    = ADDR_W - DATA_W,
    localparam int             HIGH_W    = WORD_W - DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              page_last,
    input logic [PAGE_W-1:0] pc_page,
    input logic              busy,
    input logic              rom_rd,
    input logic [ADDR_W-1:0] rom_addr,
    input logic [WORD_W-1:0] rom_data,
    input logic              dst_we,
    input logic [DA_W-1:0]   cfg_rd_addr,
    input logic [DATA_W-1:0] cfg_rd_data,
    input logic [DATA_W-1:0] tbl_ptr,
    input logic [HIGH_W-1:0] high_val
);
    p_curpage_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !page_last) |=> (rom_addr == {$past(pc_page), $past(tbl_ptr)}));

    p_lastpage_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && page_last) |=> (rom_addr == {{PAGE_W{1'b1}}, $past(tbl_ptr)}));

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && rom_rd));

    p_deliver_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |=> (dst_we && busy));

    p_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |=> !busy);

    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rom_rd);

    p_high_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |=> (high_val == $past(rom_data[WORD_W-1:DATA_W])));

    p_high_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_we |=> $stable(high_val));

    p_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_addr == HIGH_ADDR) |-> (cfg_rd_data[DATA_W-1:HIGH_W] == '0));
endmodule

bind tblrd_unit tblrd_unit_chk #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .DATA_W(DATA_W), .DA_W(DA_W), .HIGH_ADDR(HIGH_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .page_last   (page_last),
    .pc_page     (pc_page),
    .busy        (busy),
    .rom_rd      (rom_rd),
    .rom_addr    (rom_addr),
    .rom_data    (rom_data),
    .dst_we      (dst_we),
    .cfg_rd_addr (cfg_rd_addr),
    .cfg_rd_data (cfg_rd_data),
    .tbl_ptr     (tbl_ptr),
    .high_val    (high_val)
);

// File: tb/tblrd_unit_test.sv
module tblrd_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [5:0] cfg_wr_addr = '0;
    logic [7:0] cfg_wr_data = '0;
    logic [5:0] cfg_rd_addr = '0;
    logic [7:0] cfg_rd_data;
    logic       start = 1'b0;
    logic       page_last = 1'b0;
    logic [5:0] dest_sel = '0;
    logic [1:0] pc_page = '0;
    logic       rom_rd;
    logic [9:0] rom_addr;
    logic [13:0] rom_data = '0;
    logic       dst_we;
    logic [5:0] dst_addr;
    logic [7:0] dst_data;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tblrd_unit uut (.*);

    function automatic logic [13:0] rom_word(input int a);
        return 14'(((a * 613) + 11) ^ (a << 5) ^ 14'h3000);
    endfunction

    always @(posedge clk) begin
        if (rom_rd) rom_data <= rom_word(int'(rom_addr));
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [5:0] a, input logic [7:0] d);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic read_reg(input string req, input logic [5:0] a, input logic [7:0] exp);
        cfg_rd_addr = a;
        #1;
        check(req, 32'(cfg_rd_data), 32'(exp));
    endtask

    task automatic lookup(input logic last, input logic [1:0] pg,
                          input logic [7:0] ptr, input logic [5:0] dst);
        logic [9:0] ea;
        write_reg(6'h07, ptr);
        ea = last ? {2'b11, ptr} : {pg, ptr};
        start = 1'b1; page_last = last; pc_page = pg; dest_sel = dst;
        @(negedge clk);
        start = 1'b0; pc_page = ~pg;
        check(last ? "R4 addr" : "R3 addr", 32'(rom_addr), 32'(ea));
        check("R8 rom_rd first cycle", 32'({busy, rom_rd, dst_we}), 32'(3'b110));
        @(negedge clk);
        check("R5 dst strobe", 32'({busy, rom_rd, dst_we}), 32'(3'b101));
        check("R5 dst_addr", 32'(dst_addr), 32'(dst));
        check("R5 dst_data", 32'(dst_data), 32'(rom_word(int'(ea)) & 14'h00FF));
        @(negedge clk);
        check("R8 idle after two", 32'({busy, dst_we}), 32'(0));
        read_reg("R6 high", 6'h08, {2'b00, rom_word(int'(ea))[13:8]});
    endtask

    // {page_last, pc_page, ptr, dest}
    localparam logic [16:0] VEC [6] = '{
        {1'b0, 2'd0, 8'h00, 6'h20},
        {1'b0, 2'd1, 8'h5A, 6'h21},
        {1'b0, 2'd2, 8'hFF, 6'h3F},
        {1'b1, 2'd0, 8'h13, 6'h22},
        {1'b1, 2'd2, 8'hC4, 6'h2A},
        {1'b0, 2'd3, 8'h80, 6'h30}
    };

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy/rd/we in reset", 32'({busy, rom_rd, dst_we}), 32'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs idle", 32'({busy, rom_rd, dst_we}), 32'(0));
        read_reg("R1 pointer reset", 6'h07, 8'h00);
        read_reg("R1 high reset", 6'h08, 8'h00);

        for (int i = 0; i < 6; i++) begin
            lookup(VEC[i][16], VEC[i][15:14], VEC[i][13:6], VEC[i][5:0]);
        end

        // R2 pointer readback
        write_reg(6'h07, 8'hA5);
        read_reg("R2 pointer readback", 6'h07, 8'hA5);

        // R7 write to high register ignored
        lookup(1'b0, 2'd1, 8'h37, 6'h25);
        write_reg(6'h08, 8'hFF);
        read_reg("R7 high unchanged", 6'h08, {2'b00, rom_word(10'h137)[13:8]});
        read_reg("R7 pointer unchanged", 6'h07, 8'h37);

        // R10 other addresses read zero
        read_reg("R10 addr 20H", 6'h20, 8'h00);
        read_reg("R10 addr 06H", 6'h06, 8'h00);

        // R9 start held during busy is ignored
        write_reg(6'h07, 8'h44);
        start = 1'b1; page_last = 1'b1; dest_sel = 6'h2E;
        @(negedge clk);
        dest_sel = 6'h11; page_last = 1'b0; pc_page = 2'd0;
        @(negedge clk);
        check("R9 dst_addr keeps first", 32'(dst_addr), 32'(6'h2E));
        check("R9 dst_data first word", 32'(dst_data), 32'(rom_word(10'h344) & 14'h00FF));
        @(negedge clk);
        start = 1'b0;
        check("R9 no restart while busy", 32'({busy, rom_rd}), 32'(0));
        read_reg("R9 high from first", 6'h08, {2'b00, rom_word(10'h344)[13:8]});

        // R1 reset mid-operation clears registers
        start = 1'b1; page_last = 1'b0;
        @(negedge clk);
        start = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset aborts lookup", 32'({busy, rom_rd, dst_we}), 32'(0));
        read_reg("R1 pointer cleared", 6'h07, 8'h00);
        read_reg("R1 high cleared", 6'h08, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule